// File: doc/BRIEF.md
# Single-Channel DMA-to-AHB Master Bridge

This block lets an on-chip DMA requester reach system memory over an AHB bus. The requester hands over one access at a time (address, direction, size code and write data). The bridge asks the arbiter for the bus and drives one NONSEQ single transfer. It then returns a completion pulse with an error flag and, for reads, the data. Byte and halfword data travel on the low bits of the requester's data buses. On the AHB side they sit in the big-endian lane that the address selects.

If a slave answers RETRY or SPLIT, the bridge asks for the bus again and repeats the same transfer. The requester sees nothing until an OKAY or ERROR ends the access. When the arbiter parks the bus on the bridge and no access is pending, the bridge drives IDLE, so it can serve as the default master. The request side is a valid/ready handshake. The bridge raises `req_ready` only while it holds no access, and the requester must keep the request fields stable while `req_valid` is high. The completion side has no back-pressure: `rsp_valid` is a one-cycle pulse, and the requester must capture it.

Top module: `dma_ahb_master`

## Requirements
- R1: `hburst` is always 000 (SINGLE), `hlock` always 0, `hprot` always 0000, and `htrans` only ever shows IDLE (00) or NONSEQ (10).
- R2: `req_ready` is high after reset and whenever no access is held. It drops on the edge that accepts a request (`req_valid` and `req_ready` both high) and rises again together with the completion pulse.
- R3: A transfer carries the accepted `req_addr` on `haddr` and `req_write` on `hwrite`. `hsize` is set from `req_size`: 00 gives byte 000, 01 gives halfword 001, 10 gives word 010, and the unused code 11 is treated as a word, giving 010. The address and control outputs stay stable while the slave holds `hready` low in the address phase.
- R4: In the data phase of a write, `hwdata` holds the byte `req_wdata[7:0]` copied into all four lanes, or the halfword `req_wdata[15:0]` copied into both halves, or the word unchanged. It stays stable while the data phase is extended.
- R5: Read data is taken big-endian. A byte at address offset a comes from `hrdata` bits 31-8a down to 24-8a. A halfword comes from bits 31:16 when address bit 1 is 0, and from bits 15:0 when it is 1. A word is taken whole. Bytes and halfwords are zero-extended into `rsp_rdata`, and `rsp_rdata` is 0 for writes.
- R6: A data phase that ends with `hready` high and `hresp` OKAY (00) produces a one-cycle `rsp_valid` pulse with `rsp_error` low. An ERROR (01) response gives the same pulse with `rsp_error` high. A write that ends in ERROR leaves the memory as it was.
- R7: A data phase that ends with RETRY (10) or SPLIT (11) produces no completion. Instead, `hbusreq` is raised again on the next cycle and the same transfer is issued again, until it ends in OKAY or ERROR.
- R8: When the bus is not granted at acceptance, `hbusreq` is high from the accepting edge until the address phase is accepted. `htrans` stays IDLE while the bridge waits for the grant.
- R9: When the bridge is already granted with `hready` high and the slave inserts no wait states, NONSEQ is driven right after the accepting edge. `rsp_valid` is then high in the cycle after the second rising edge that follows acceptance.
- R10: With no access held, `htrans` is IDLE and `hbusreq` is low, even while `hgrant` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Bridge can accept an access |
| req_addr | input | ADDR_W | Byte address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 word |
| req_wdata | input | 32 | Write data, low-aligned |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Completion ended in ERROR |
| rsp_rdata | output | 32 | Read data, low-aligned |
| hgrant | input | 1 | Bus granted to this master |
| hready | input | 1 | Bus transfer ready |
| hresp | input | 2 | Slave response |
| hrdata | input | 32 | Read data bus |
| hbusreq | output | 1 | Bus request |
| hlock | output | 1 | Lock request, always 0 |
| htrans | output | 2 | Transfer type |
| haddr | output | ADDR_W | Transfer address |
| hwrite | output | 1 | Transfer direction |
| hsize | output | 3 | Transfer size |
| hburst | output | 3 | Burst type, always SINGLE |
| hprot | output | 4 | Protection, always 0000 |
| hwdata | output | 32 | Write data bus |

## Verification
The bench first runs directed accesses against a parked grant with a zero-wait slave. These separate the lane mapping of each size and offset, and they check the exact completion cycle. Forced ERROR and forced alternating RETRY/SPLIT sequences show the difference between ending an access and repeating it. A run with the grant withheld shows the bus request being held. A long random mix then varies grant, wait states, response kind, size and alignment together. A shadow of the memory kept at the requester level would expose any data steered into the wrong lane or any write committed twice.

// File: rtl/dahb_pkg.sv
package dahb_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned LANES = BUS_W / 8;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;
  localparam logic [1:0] SZ_WIDE = 2'b11;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;

  localparam logic [1:0] RS_OKAY  = 2'b00;
  localparam logic [1:0] RS_ERROR = 2'b01;
  localparam logic [1:0] RS_RETRY = 2'b10;
  localparam logic [1:0] RS_SPLIT = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_DATA
  } bstate_t;
endpackage

// File: rtl/dahb_lanes.sv
module dahb_lanes
  import dahb_pkg::*;
(
  input  logic [1:0]       size,
  input  logic [1:0]       offset,
  input  logic [BUS_W-1:0] low_wdata,
  output logic [BUS_W-1:0] bus_wdata,
  input  logic [BUS_W-1:0] bus_rdata,
  output logic [BUS_W-1:0] low_rdata
);
  // write side: lane 0 is the most significant byte (big-endian)
  for (genvar i = 0; i < LANES; i++) begin : g_wlane
    localparam int HI   = BUS_W - 1 - 8 * i;
    localparam bit EVEN = (i % 2) == 0;
    assign bus_wdata[HI -: 8] =
      (size == SZ_BYTE) ? low_wdata[7:0] :
      (size == SZ_HALF) ? (EVEN ? low_wdata[15:8] : low_wdata[7:0]) :
                          low_wdata[HI -: 8];
  end

  // read side: pick the addressed lane and zero-extend
  always_comb begin
    case (size)
      SZ_BYTE: low_rdata = {{(BUS_W-8){1'b0}},
                            bus_rdata[BUS_W - 1 - 8 * int'(offset) -: 8]};
      SZ_HALF: low_rdata = {{(BUS_W-16){1'b0}},
                            offset[1] ? bus_rdata[15:0] : bus_rdata[31:16]};
      default: low_rdata = bus_rdata;
    endcase
  end
endmodule

// File: rtl/dahb_ctrl.sv
module dahb_ctrl
  import dahb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic              rsp_error,
  output logic [BUS_W-1:0]  rsp_rdata,
  input  logic              hgrant,
  input  logic              hready,
  input  logic [1:0]        hresp,
  output logic              hbusreq,
  output logic [1:0]        htrans,
  output logic [ADDR_W-1:0] haddr,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [BUS_W-1:0]  hwdata,
  // lane steering hookup
  output logic [1:0]        lane_size,
  output logic [1:0]        lane_off,
  output logic [BUS_W-1:0]  lane_wlow,
  input  logic [BUS_W-1:0]  lane_wbus,
  input  logic [BUS_W-1:0]  lane_rlow
);
  bstate_t           st;
  logic [ADDR_W-1:0] q_addr;
  logic              q_write;
  logic [1:0]        q_size;
  logic [BUS_W-1:0]  q_wdata;

  assign lane_size = q_size;
  assign lane_off  = q_addr[1:0];
  assign lane_wlow = q_wdata;

  function automatic logic [2:0] size_code(input logic [1:0] s);
    return {1'b0, (s == SZ_WIDE) ? SZ_WORD : s};
  endfunction

  wire take     = req_valid && req_ready;
  wire own_next = hgrant && hready;
  wire reissue  = hresp == RS_RETRY || hresp == RS_SPLIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      q_addr    <= '0;
      q_write   <= 1'b0;
      q_size    <= SZ_BYTE;
      q_wdata   <= '0;
      req_ready <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_error <= 1'b0;
      rsp_rdata <= '0;
      hbusreq   <= 1'b0;
      htrans    <= TR_IDLE;
      haddr     <= '0;
      hwrite    <= 1'b0;
      hsize     <= 3'b000;
      hwdata    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: if (take) begin
          q_addr    <= req_addr;
          q_write   <= req_write;
          q_size    <= req_size;
          q_wdata   <= req_wdata;
          req_ready <= 1'b0;
          if (own_next) begin
            // parked on this master: issue at once
            htrans <= TR_NONSEQ;
            haddr  <= req_addr;
            hwrite <= req_write;
            hsize  <= size_code(req_size);
            st     <= ST_ADDR;
          end else begin
            hbusreq <= 1'b1;
            st      <= ST_REQ;
          end
        end
        ST_REQ: if (own_next) begin
          htrans <= TR_NONSEQ;
          haddr  <= q_addr;
          hwrite <= q_write;
          hsize  <= size_code(q_size);
          st     <= ST_ADDR;
        end
        ST_ADDR: if (hready) begin
          htrans  <= TR_IDLE;
          hbusreq <= 1'b0;
          hwdata  <= lane_wbus;
          st      <= ST_DATA;
        end
        ST_DATA: if (hready) begin
          if (reissue) begin
            hbusreq <= 1'b1;
            st      <= ST_REQ;
          end else begin
            rsp_valid <= 1'b1;
            rsp_error <= hresp == RS_ERROR;
            rsp_rdata <= q_write ? '0 : lane_rlow;
            req_ready <= 1'b1;
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_ahb_master.sv
module dma_ahb_master
  import dahb_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_error,
  output logic [31:0]       rsp_rdata,
  input  logic              hgrant,
  input  logic              hready,
  input  logic [1:0]        hresp,
  input  logic [31:0]       hrdata,
  output logic              hbusreq,
  output logic              hlock,
  output logic [1:0]        htrans,
  output logic [ADDR_W-1:0] haddr,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [3:0]        hprot,
  output logic [31:0]       hwdata
);
  logic [1:0]       l_size;
  logic [1:0]       l_off;
  logic [BUS_W-1:0] l_wlow;
  logic [BUS_W-1:0] l_wbus;
  logic [BUS_W-1:0] l_rlow;

  assign hlock  = 1'b0;
  assign hburst = 3'b000;
  assign hprot  = 4'b0000;

  dahb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_error (rsp_error),
    .rsp_rdata (rsp_rdata),
    .hgrant    (hgrant),
    .hready    (hready),
    .hresp     (hresp),
    .hbusreq   (hbusreq),
    .htrans    (htrans),
    .haddr     (haddr),
    .hwrite    (hwrite),
    .hsize     (hsize),
    .hwdata    (hwdata),
    .lane_size (l_size),
    .lane_off  (l_off),
    .lane_wlow (l_wlow),
    .lane_wbus (l_wbus),
    .lane_rlow (l_rlow)
  );

  dahb_lanes u_lanes (
    .size      (l_size),
    .offset    (l_off),
    .low_wdata (l_wlow),
    .bus_wdata (l_wbus),
    .bus_rdata (hrdata),
    .low_rdata (l_rlow)
  );
endmodule

// File: rtl/dahb_checker.sv
module dahb_checker #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_error,
  input logic              hready,
  input logic [1:0]        hresp,
  input logic              hbusreq,
  input logic [1:0]        htrans,
  input logic [ADDR_W-1:0] haddr,
  input logic              hwrite,
  input logic [2:0]        hsize,
  input logic [31:0]       hwdata
);
  // tracks whether this master owns the current data phase
  logic dph;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dph <= 1'b0;
    else if (hready) dph <= htrans == 2'b10;
  end

  AST_HTRANS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    htrans == 2'b00 || htrans == 2'b10); // R1
  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    htrans == 2'b10 && !hready |=>
      htrans == 2'b10 && $stable(haddr) && $stable(hwrite) && $stable(hsize)); // R3
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dph && !hready |=> $stable(hwdata)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dph && hready && !hresp[1] |=> rsp_valid && rsp_error == $past(hresp[0])); // R6
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R6
  AST_RETRY_AGAIN: assert property (@(posedge clk) disable iff (!rst_n)
    dph && hready && hresp[1] |=> !rsp_valid && hbusreq); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> htrans == 2'b00 && !hbusreq); // R10
endmodule

bind dma_ahb_master dahb_checker #(.ADDR_W(ADDR_W)) u_dahb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_error (rsp_error),
  .hready    (hready),
  .hresp     (hresp),
  .hbusreq   (hbusreq),
  .htrans    (htrans),
  .haddr     (haddr),
  .hwrite    (hwrite),
  .hsize     (hsize),
  .hwdata    (hwdata)
);

// File: tb/dma_ahb_master_bench.sv
module dma_ahb_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 150000;
  localparam int N_RAND     = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_error;
  logic [31:0] rsp_rdata;
  logic        hgrant = 1'b1;
  logic        hready_s;
  logic [1:0]  hresp_s;
  logic [31:0] hrdata_s;
  logic        hbusreq, hlock, hwrite;
  logic [1:0]  htrans;
  logic [31:0] haddr, hwdata;
  logic [2:0]  hsize, hburst;
  logic [3:0]  hprot;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_ahb_master u_dma_ahb_master (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .hgrant(hgrant), .hready(hready_s), .hresp(hresp_s), .hrdata(hrdata_s),
    .hbusreq(hbusreq), .hlock(hlock), .htrans(htrans), .haddr(haddr),
    .hwrite(hwrite), .hsize(hsize), .hburst(hburst), .hprot(hprot),
    .hwdata(hwdata)
  );

  // ---------------- reference functions ----------------
  function automatic logic [31:0] init_word(int i);
    return (32'h01020304 * (i + 1)) ^ 32'hC3A5_5A3C;
  endfunction
  function automatic logic [2:0] exp_hsize(logic [1:0] s);
    return (s == 2'b11) ? 3'b010 : {1'b0, s};
  endfunction
  function automatic logic [31:0] exp_lanes(logic [1:0] s, logic [31:0] d);
    case (s)
      2'b00:   return {4{d[7:0]}};
      2'b01:   return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction
  function automatic logic [31:0] pick(logic [1:0] s, logic [1:0] off, logic [31:0] w);
    case (s)
      2'b00:   return (w >> (8 * (3 - int'(off)))) & 32'hFF;
      2'b01:   return off[1] ? {16'h0, w[15:0]} : {16'h0, w[31:16]};
      default: return w;
    endcase
  endfunction
  function automatic logic [31:0] merge(logic [1:0] s, logic [1:0] off,
                                        logic [31:0] w, logic [31:0] d);
    logic [31:0] m;
    int sh;
    case (s)
      2'b00:   begin sh = 8 * (3 - int'(off)); m = 32'hFF << sh; end
      2'b01:   begin sh = off[1] ? 0 : 16; m = 32'hFFFF << sh; end
      default: begin sh = 0; m = 32'hFFFF_FFFF; end
    endcase
    return (w & ~m) | ((d << sh) & m);
  endfunction

  // ---------------- control shared with the slave model ----------------
  int          gnt_mode = 1;    // 0 low, 1 high, 2 random
  bit          rand_mode = 1'b0;
  bit          force_err = 1'b0;
  int          force_n = 0;
  int          txn_id = 0;
  logic [31:0] cur_addr = '0;
  logic        cur_write = 1'b0;
  logic [1:0]  cur_size = '0;
  logic [31:0] cur_wdata = '0;

  always @(negedge clk) begin
    if (gnt_mode == 0)      hgrant <= 1'b0;
    else if (gnt_mode == 1) hgrant <= 1'b1;
    else                    hgrant <= ($urandom % 4) != 0;
  end

  // ---------------- slave model ----------------
  logic [31:0] mem [16];
  logic        dp_act, dp_w;
  logic [31:0] dp_addr;
  logic [1:0]  dp_sz, rk;
  int          left, att, last_id, attempts;
  logic [1:0]  last_kind;
  int          s_chk = 0, s_fail = 0;
  int          l_n, a_n;
  logic [1:0]  kind;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hready_s <= 1'b1; hresp_s <= 2'b00; hrdata_s <= '0;
      dp_act <= 1'b0; dp_w <= 1'b0; dp_addr <= '0; dp_sz <= '0; rk <= 2'b00;
      left <= 0; att <= 0; last_id <= -1; attempts <= 0; last_kind <= 2'b00;
      for (int i = 0; i < 16; i++) mem[i] <= init_word(i);
    end else if (hready_s) begin
      if (dp_act && dp_w && rk == 2'b00) begin
        s_chk = s_chk + 1;
        if (hwdata !== exp_lanes(dp_sz == 2'b11 ? 2'b10 : dp_sz, cur_wdata)) begin
          s_fail = s_fail + 1;
          $display("FAIL R4 hwdata act=%h exp=%h", hwdata,
                   exp_lanes(dp_sz == 2'b11 ? 2'b10 : dp_sz, cur_wdata));
        end
        mem[dp_addr[5:2]] <= merge(dp_sz == 2'b11 ? 2'b10 : dp_sz, dp_addr[1:0],
          mem[dp_addr[5:2]], pick(dp_sz == 2'b11 ? 2'b10 : dp_sz, dp_addr[1:0], hwdata));
      end
      if (htrans == 2'b10) begin
        s_chk = s_chk + 1;
        if (haddr !== cur_addr || hwrite !== cur_write || hsize !== exp_hsize(cur_size)) begin
          s_fail = s_fail + 1;
          $display("FAIL R3 addr phase act=%h/%b/%b exp=%h/%b/%b", haddr, hwrite, hsize,
                   cur_addr, cur_write, exp_hsize(cur_size));
        end
        a_n = (txn_id == last_id) ? att + 1 : 0;
        last_id <= txn_id; att <= a_n; attempts <= a_n + 1;
        if (force_err)          kind = 2'b01;
        else if (a_n < force_n) kind = a_n[0] ? 2'b11 : 2'b10;
        else if (rand_mode) begin
          case ($urandom % 10)
            0: kind = 2'b01;
            1: kind = 2'b10;
            2: kind = 2'b11;
            default: kind = 2'b00;
          endcase
        end else kind = 2'b00;
        last_kind <= kind;
        l_n = (rand_mode ? int'($urandom % 3) : 0) + (kind != 2'b00 ? 1 : 0);
        dp_act <= 1'b1; dp_w <= hwrite; dp_addr <= haddr;
        dp_sz <= hsize[1:0]; rk <= kind; left <= l_n;
        if (l_n == 0) begin
          hready_s <= 1'b1; hresp_s <= 2'b00; hrdata_s <= mem[haddr[5:2]];
        end else begin
          hready_s <= 1'b0; hrdata_s <= '0;
          hresp_s <= (kind != 2'b00 && l_n == 1) ? kind : 2'b00;
        end
      end else begin
        dp_act <= 1'b0; hready_s <= 1'b1; hresp_s <= 2'b00;
      end
    end else begin
      l_n = left - 1;
      left <= l_n;
      if (l_n == 0) begin
        hready_s <= 1'b1; hresp_s <= rk; hrdata_s <= mem[dp_addr[5:2]];
      end else begin
        hready_s <= 1'b0;
        hresp_s <= (rk != 2'b00 && l_n == 1) ? rk : 2'b00;
      end
    end
  end

  // ---------------- checking infrastructure ----------------
  int chk = 0, fail = 0;
  logic [31:0] shadow [16];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    chk = chk + 1;
    if (!ok) begin
      fail = fail + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  logic        t_err;
  logic [31:0] t_rdata;
  int          t_lat;
  bit          t_nonseq1;

  // call at a falling edge
  task automatic run_txn(input logic [31:0] a, input logic w, input logic [1:0] s,
                         input logic [31:0] d);
    int guard = 0;
    while (!req_ready && guard < 200) begin @(negedge clk); guard++; end
    cur_addr = a; cur_write = w; cur_size = s; cur_wdata = d;
    txn_id = txn_id + 1;
    req_addr = a; req_write = w; req_size = s; req_wdata = d; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    t_nonseq1 = htrans == 2'b10;
    t_lat = 1;
    while (!rsp_valid && t_lat < 300) begin @(negedge clk); t_lat++; end
    check(rsp_valid, "R6 completion seen", {31'b0, rsp_valid}, 32'h1);
    t_err = rsp_error;
    t_rdata = rsp_rdata;
  endtask

  task automatic do_checked(input logic [31:0] a, input logic w, input logic [1:0] s,
                            input logic [31:0] d);
    logic [1:0] es;
    logic       eerr;
    es = (s == 2'b11) ? 2'b10 : s;
    run_txn(a, w, s, d);
    eerr = last_kind == 2'b01;
    check(t_err == eerr, "R6 error flag", {31'b0, t_err}, {31'b0, eerr});
    if (!t_err && !w)
      check(t_rdata == pick(es, a[1:0], shadow[a[5:2]]), "R5 read data", t_rdata,
            pick(es, a[1:0], shadow[a[5:2]]));
    if (w) check(t_rdata == 32'h0, "R5 write rdata zero", t_rdata, 32'h0);
    if (!t_err && w) shadow[a[5:2]] = merge(es, a[1:0], shadow[a[5:2]], d);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    $display("FAIL watchdog act=%0d exp=<%0d cycles", WDOG_CYC, WDOG_CYC);
    $display("%0d/%0d checks passed", chk + s_chk - fail - s_fail, chk + s_chk + 1);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    void'($urandom(32'd24681));
    for (int i = 0; i < 16; i++) shadow[i] = init_word(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state R1 R2 R10
    check(req_ready == 1'b1, "R2 ready after reset", {31'b0, req_ready}, 32'h1);
    check(rsp_valid == 1'b0, "R6 no pulse after reset", {31'b0, rsp_valid}, 32'h0);
    check(hburst == 3'b000 && hlock == 1'b0 && hprot == 4'b0000, "R1 fixed controls",
          {24'b0, hburst, hlock, hprot}, 32'h0);

    // parked grant, nothing pending R10
    for (int i = 0; i < 4; i++) begin
      check(htrans == 2'b00 && !hbusreq, "R10 idle while parked",
            {29'b0, htrans, hbusreq}, 32'h0);
      @(negedge clk);
    end

    // R9 latency on the fast path with a word write
    run_txn(32'h0, 1'b1, 2'b10, 32'h1122_3344);
    shadow[0] = 32'h1122_3344;
    check(t_nonseq1, "R9 NONSEQ right after accept", {31'b0, t_nonseq1}, 32'h1);
    check(t_lat == 3, "R9 completion cycle", t_lat, 3);
    check(req_ready == 1'b1, "R2 ready with completion", {31'b0, req_ready}, 32'h1);

    // R5 read lanes, directed literals
    for (int i = 0; i < 4; i++) begin
      run_txn(32'(i), 1'b0, 2'b00, 32'h0);
      check(t_rdata == ((32'h1122_3344 >> (24 - 8 * i)) & 32'hFF), "R5 byte lane",
            t_rdata, (32'h1122_3344 >> (24 - 8 * i)) & 32'hFF);
    end
    run_txn(32'h0, 1'b0, 2'b01, 32'h0);
    check(t_rdata == 32'h1122, "R5 upper halfword", t_rdata, 32'h1122);
    run_txn(32'h2, 1'b0, 2'b01, 32'h0);
    check(t_rdata == 32'h3344, "R5 lower halfword", t_rdata, 32'h3344);

    // R4 narrow writes observed through later reads
    do_checked(32'h2, 1'b1, 2'b00, 32'hFFFF_FFAB);
    run_txn(32'h0, 1'b0, 2'b10, 32'h0);
    check(t_rdata == 32'h1122_AB44, "R4 byte write lane", t_rdata, 32'h1122_AB44);
    do_checked(32'h0, 1'b1, 2'b01, 32'h1234_BEEF);
    run_txn(32'h0, 1'b0, 2'b10, 32'h0);
    check(t_rdata == 32'hBEEF_AB44, "R4 halfword write lane", t_rdata, 32'hBEEF_AB44);

    // R3 unused size code behaves as word
    do_checked(32'h0, 1'b0, 2'b11, 32'h0);
    check(t_rdata == 32'hBEEF_AB44, "R3 size 11 as word", t_rdata, 32'hBEEF_AB44);

    // R6 error responses, write not committed
    force_err = 1'b1;
    run_txn(32'h4, 1'b0, 2'b10, 32'h0);
    check(t_err == 1'b1, "R6 read error flag", {31'b0, t_err}, 32'h1);
    run_txn(32'h4, 1'b1, 2'b10, 32'hDEAD_0001);
    check(t_err == 1'b1, "R6 write error flag", {31'b0, t_err}, 32'h1);
    force_err = 1'b0;
    run_txn(32'h4, 1'b0, 2'b10, 32'h0);
    check(t_rdata == shadow[1], "R6 errored write left memory", t_rdata, shadow[1]);

    // R7 RETRY/SPLIT reissue
    force_n = 3;
    do_checked(32'h8, 1'b1, 2'b10, 32'hCAFE_F00D);
    check(attempts == 4, "R7 attempts after three reissues", attempts, 4);
    check(t_err == 1'b0, "R7 ends with okay", {31'b0, t_err}, 32'h0);
    do_checked(32'h8, 1'b0, 2'b10, 32'h0);
    check(attempts == 4, "R7 read reissued", attempts, 4);
    force_n = 0;

    // R8 hold bus request while grant is withheld
    gnt_mode = 0;
    repeat (2) @(negedge clk);
    txn_id = txn_id + 1;
    cur_addr = 32'hC; cur_write = 1'b0; cur_size = 2'b10; cur_wdata = '0;
    req_addr = 32'hC; req_write = 1'b0; req_size = 2'b10; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      check(hbusreq && htrans == 2'b00 && !rsp_valid, "R8 request held, no transfer",
            {29'b0, hbusreq, htrans}, 32'h4);
      @(negedge clk);
    end
    gnt_mode = 1;
    t_lat = 0;
    while (!rsp_valid && t_lat < 50) begin @(negedge clk); t_lat++; end
    check(rsp_valid && rsp_rdata == shadow[3], "R8 completes after grant", rsp_rdata,
          shadow[3]);
    @(negedge clk);
    check(!hbusreq, "R8 request dropped", {31'b0, hbusreq}, 32'h0);

    // random mix
    rand_mode = 1'b1;
    gnt_mode = 2;
    for (int n = 0; n < N_RAND; n++) begin
      logic [1:0]  s;
      logic [31:0] a;
      s = logic'($urandom % 8 == 0) ? 2'b11 : 2'($urandom % 3);
      a = 32'($urandom % 64);
      if (s == 2'b01) a[0] = 1'b0;
      if (s[1]) a[1:0] = 2'b00;
      do_checked(a, 1'($urandom % 2), s, $urandom);
    end
    check(hburst == 3'b000 && hlock == 1'b0 && hprot == 4'b0000, "R1 fixed at end",
          {24'b0, hburst, hlock, hprot}, 32'h0);

    $display("%0d/%0d checks passed", chk + s_chk - fail - s_fail, chk + s_chk);
    $finish;
  end
endmodule